// File: doc/BRIEF.md
# Asynchronous SRAM Front End for SDRAM

This block lets a legacy 16-bit processor bus treat a single-data-rate SDRAM as a plain asynchronous static RAM. The host presents a word address, byte enables, write and output enables and a chip select, as it would to an SRAM. The bridge pulls an open-drain READY line low while its internal command sequencer opens rows, issues column commands and waits out the SDRAM timing. When the access is complete it releases READY. Refresh and power-up initialization take place behind the same wait handshake, so the host never issues an SDRAM command.

The bridge keeps one open row per bank. A second access to an open row skips the activate step. An access to a different row in an open bank first closes that bank. A refresh timer requests auto-refresh at a fixed interval. The refresh is inserted only between host accesses, after all banks are closed.

Host selection is the external chip select qualified by an internal decode of the top `DEC_W` address bits against `DEC_BASE`. With `DEC_W = 0` the chip select alone selects the block. Between two accesses the host must keep the block deselected for at least three clock cycles.

Top module: `sram_sdram_bridge`

## Requirements
- R1: After reset the SDRAM command sequence is exactly as follows, with only NOP commands before and between these steps:
  - wait at least `T_PWRUP` cycles;
  - precharge-all (address bit 10 = 1);
  - two auto-refresh commands;
  - mode register load with address 0x020 (CAS latency 2, burst length 1, sequential).
- R2: From reset until the mode register load, READY is held low whether or not the block is selected. No activate, read or write command is issued before that point.
- R3: READY is open-drain: it is either driven 0 or left high-impedance. After initialization it is pulled low as soon as the block is selected and stays low until the access completes. It is released whenever the block is not selected.
- R4: After initialization, one auto-refresh is issued every `REF_INTERVAL` cycles, with a tolerance of one refresh over the run. Refresh happens only when every bank is precharged, and a refresh request waits until any host access in progress has finished.
- R5: An activate comes at least `T_RP` cycles after a precharge of its bank. A read or write comes at least `T_RCD` cycles after the activate of its bank.
- R6: Open rows are tracked per bank:
  - an access to the open row of its bank goes straight to the column command;
  - an access to a closed bank activates the row first;
  - an access to a different row precharges that bank and then activates.
  - The READY-low time is therefore ordered: open-row hit < closed bank < row miss.
- R7: On a write, the active-low host enables map to the SDRAM data mask: upper enable to DQM bit 1 and lower enable to DQM bit 0. Only the enabled bytes change, and a write with both enables inactive changes nothing.
- R8: Read data is captured `CAS_LAT` cycles after the read command. It is driven on the host data bus while the block is selected, OE is low and WE is high; otherwise the block leaves the bus high-impedance.
- R9: An access whose top `DEC_W` address bits differ from `DEC_BASE` is ignored: READY stays released and SDRAM contents are unchanged.
- R10: The host word address maps to SDRAM coordinates as follows: column = address[8:0], bank = address[10:9], row = address[22:11] (with the default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge and SDRAM clock |
| hostRstN | input | 1 | Active-low reset |
| hostAddr | input | 24 | Host word address |
| hostData | inout | 16 | Host data bus |
| hostUbN | input | 1 | Upper byte enable, active low |
| hostLbN | input | 1 | Lower byte enable, active low |
| hostWeN | input | 1 | Write enable, active low |
| hostOeN | input | 1 | Output enable, active low |
| hostCsN | input | 1 | RAM chip select, active low |
| hostReady | output | 1 | Open-drain ready, 0 = wait |
| sdrCke | output | 1 | SDRAM clock enable |
| sdrCsN | output | 1 | SDRAM chip select |
| sdrRasN | output | 1 | SDRAM row strobe |
| sdrCasN | output | 1 | SDRAM column strobe |
| sdrWeN | output | 1 | SDRAM write strobe |
| sdrBa | output | 2 | SDRAM bank address |
| sdrAddr | output | 13 | SDRAM multiplexed address |
| sdrDqm | output | 2 | SDRAM byte data mask |
| sdrDqOut | output | 16 | SDRAM write data |
| sdrDqIn | input | 16 | SDRAM read data |
| sdrDqOe | output | 1 | SDRAM data output enable |

## Verification
Directed reads are aimed at a closed bank, then at the row just opened, then at another row of the same bank. Their READY-low times separate the three row-tracking paths.

Writes with each combination of byte enables are each followed by a read of the same word, which isolates the mask mapping. A write outside the decode window is followed by a read of its in-window alias, which shows whether the decode gate really suppresses the access.

Random traffic is confined to a few rows in every bank so that hits, misses and refresh-forced reopenings interleave. A protocol-checking SDRAM model flags any command issued against closed rows or inside the precharge and activate delays.

// File: rtl/sdram_bridge_pkg.sv
package sdram_bridge_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE_BANK, CMD_PRE_ALL, CMD_REF,
    CMD_MRS, CMD_ACT, CMD_READ, CMD_WRITE
  } sdrCmd_e;

  typedef struct packed {
    sdrCmd_e cmd;      // command to place on the SDRAM pins this cycle
    logic    capture;  // latch host address, data and enables
    logic    latchRd;  // sample SDRAM read data this cycle
  } ctrlStrobe_t;

  // {rasN, casN, weN}
  function automatic logic [2:0] cmdPins(sdrCmd_e c);
    case (c)
      CMD_ACT:      return 3'b011;
      CMD_READ:     return 3'b101;
      CMD_WRITE:    return 3'b100;
      CMD_PRE_BANK: return 3'b010;
      CMD_PRE_ALL:  return 3'b010;
      CMD_REF:      return 3'b001;
      CMD_MRS:      return 3'b000;
      default:      return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_bridge_ctrl.sv
module sdram_bridge_ctrl
  import sdram_bridge_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int T_PWRUP      = 2000,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int CAS_LAT      = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selReq,
  input  logic [BANK_W-1:0] curBank,
  input  logic [ROW_W-1:0]  curRow,
  input  logic              curWrite,
  output ctrlStrobe_t       strobe,
  output logic              initDone,
  output logic              accessDone
);

  localparam int BANKS = 1 << BANK_W;
  localparam int M1 = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
  localparam int M2 = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3 = (M2 > T_RCD) ? M2 : T_RCD;
  localparam int M4 = (M3 > T_MRD) ? M3 : T_MRD;
  localparam int M5 = (M4 > T_WR) ? M4 : T_WR;
  localparam int T_MAX = (M5 > CAS_LAT) ? M5 : CAS_LAT;
  localparam int TMR_W = $clog2(T_MAX + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  typedef enum logic [3:0] {
    S_PWRUP, S_INIT_PRE, S_INIT_REF1, S_INIT_REF2, S_INIT_MRS,
    S_IDLE, S_DECIDE, S_PRE, S_ACT, S_READ, S_RDLAT, S_WRITE,
    S_REF_PRE, S_REF, S_WAIT
  } state_e;

  state_e             state, waitNext;
  logic [TMR_W-1:0]   timer;
  logic [REF_W-1:0]   refCnt;
  logic               refPending;
  logic [BANKS-1:0]   rowOpen;
  logic [ROW_W-1:0]   openRow [BANKS];
  logic               rowHit, startAcc;

  assign rowHit   = rowOpen[curBank] && (openRow[curBank] == curRow);
  assign startAcc = (state == S_IDLE) && !refPending && selReq && !accessDone;

  // refresh interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= REF_W'(REF_INTERVAL - 1);
      refPending <= 1'b0;
    end else begin
      if (state == S_REF) refPending <= 1'b0;
      if (initDone) begin
        if (refCnt == '0) begin
          refCnt     <= REF_W'(REF_INTERVAL - 1);
          refPending <= 1'b1;
        end else begin
          refCnt <= refCnt - 1'b1;
        end
      end
    end
  end

  // command sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_PWRUP;
      waitNext   <= S_IDLE;
      timer      <= TMR_W'(T_PWRUP - 1);
      initDone   <= 1'b0;
      accessDone <= 1'b0;
      rowOpen    <= '0;
      for (int b = 0; b < BANKS; b++) openRow[b] <= '0;
    end else begin
      if (!selReq) accessDone <= 1'b0;
      case (state)
        S_PWRUP: begin
          if (timer == '0) state <= S_INIT_PRE;
          else timer <= timer - 1'b1;
        end
        S_INIT_PRE: begin
          timer <= TMR_W'(T_RP - 2); waitNext <= S_INIT_REF1; state <= S_WAIT;
        end
        S_INIT_REF1: begin
          timer <= TMR_W'(T_RFC - 2); waitNext <= S_INIT_REF2; state <= S_WAIT;
        end
        S_INIT_REF2: begin
          timer <= TMR_W'(T_RFC - 2); waitNext <= S_INIT_MRS; state <= S_WAIT;
        end
        S_INIT_MRS: begin
          initDone <= 1'b1;
          timer <= TMR_W'(T_MRD - 2); waitNext <= S_IDLE; state <= S_WAIT;
        end
        S_IDLE: begin
          if (refPending) state <= (rowOpen != '0) ? S_REF_PRE : S_REF;
          else if (startAcc) state <= S_DECIDE;
        end
        S_DECIDE: begin
          if (rowHit) state <= curWrite ? S_WRITE : S_READ;
          else if (rowOpen[curBank]) state <= S_PRE;
          else state <= S_ACT;
        end
        S_PRE: begin
          rowOpen[curBank] <= 1'b0;
          timer <= TMR_W'(T_RP - 2); waitNext <= S_ACT; state <= S_WAIT;
        end
        S_ACT: begin
          rowOpen[curBank] <= 1'b1;
          openRow[curBank] <= curRow;
          timer <= TMR_W'(T_RCD - 2);
          waitNext <= curWrite ? S_WRITE : S_READ;
          state <= S_WAIT;
        end
        S_READ: begin
          timer <= TMR_W'(CAS_LAT - 1); state <= S_RDLAT;
        end
        S_RDLAT: begin
          if (timer == '0) begin
            accessDone <= 1'b1;
            state      <= S_IDLE;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_WRITE: begin
          accessDone <= 1'b1;
          timer <= TMR_W'(T_WR - 2); waitNext <= S_IDLE; state <= S_WAIT;
        end
        S_REF_PRE: begin
          rowOpen <= '0;
          timer <= TMR_W'(T_RP - 2); waitNext <= S_REF; state <= S_WAIT;
        end
        S_REF: begin
          timer <= TMR_W'(T_RFC - 2); waitNext <= S_IDLE; state <= S_WAIT;
        end
        S_WAIT: begin
          if (timer == '0) state <= waitNext;
          else timer <= timer - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    strobe.capture = startAcc;
    strobe.latchRd = (state == S_RDLAT) && (timer == '0);
    case (state)
      S_INIT_PRE, S_REF_PRE:         strobe.cmd = CMD_PRE_ALL;
      S_PRE:                         strobe.cmd = CMD_PRE_BANK;
      S_INIT_REF1, S_INIT_REF2, S_REF: strobe.cmd = CMD_REF;
      S_INIT_MRS:                    strobe.cmd = CMD_MRS;
      S_ACT:                         strobe.cmd = CMD_ACT;
      S_READ:                        strobe.cmd = CMD_READ;
      S_WRITE:                       strobe.cmd = CMD_WRITE;
      default:                       strobe.cmd = CMD_NOP;
    endcase
  end

  // R2: no row or column command before the mode register is loaded
  a_r2_no_access_before_init: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd inside {CMD_ACT, CMD_READ, CMD_WRITE}) |-> initDone);

  // R5: activate never directly follows a precharge
  a_r5_trp_before_act: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_ACT) |-> !($past(strobe.cmd) inside {CMD_PRE_BANK, CMD_PRE_ALL}));

  // R5: column command never directly follows an activate
  a_r5_trcd_before_rw: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd inside {CMD_READ, CMD_WRITE}) |-> ($past(strobe.cmd) != CMD_ACT));

  // R4: refresh only with every bank closed
  a_r4_ref_rows_closed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_REF) |-> (rowOpen == '0));

  // R6: column command only to a bank holding the requested row
  a_r6_rw_to_open_row: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd inside {CMD_READ, CMD_WRITE}) |-> rowHit);

endmodule

// File: rtl/sdram_bridge_dp.sv
module sdram_bridge_dp
  import sdram_bridge_pkg::*;
#(
  parameter int LOC_W   = 23,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int SA_W    = 13,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LOC_W-1:0]  hostAddr,
  input  logic [15:0]       hostDataIn,
  input  logic              hostUbN,
  input  logic              hostLbN,
  input  logic              hostWeN,
  output logic [BANK_W-1:0] curBank,
  output logic [ROW_W-1:0]  curRow,
  output logic              curWrite,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic [BANK_W-1:0] sdrBa,
  output logic [SA_W-1:0]   sdrAddr,
  output logic [1:0]        sdrDqm,
  output logic [15:0]       sdrDqOut,
  output logic              sdrDqOe,
  input  logic [15:0]       sdrDqIn,
  output logic [15:0]       rdData
);

  localparam logic [SA_W-1:0] MODE_WORD = SA_W'(CAS_LAT) << 4;
  localparam logic [SA_W-1:0] ALL_BANKS = SA_W'(1) << 10;

  logic [LOC_W-1:0] addrQ;
  logic [15:0]      dataQ;
  logic [1:0]       maskQ;
  logic [COL_W-1:0] curCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      maskQ    <= 2'b11;
      curWrite <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ    <= hostAddr;
        dataQ    <= hostDataIn;
        maskQ    <= {hostUbN, hostLbN};
        curWrite <= !hostWeN;
      end
      if (strobe.latchRd) rdData <= sdrDqIn;
    end
  end

  assign curCol  = addrQ[COL_W-1:0];
  assign curBank = addrQ[COL_W +: BANK_W];
  assign curRow  = addrQ[COL_W+BANK_W +: ROW_W];

  always_comb begin
    {sdrRasN, sdrCasN, sdrWeN} = cmdPins(strobe.cmd);
    sdrBa    = curBank;
    sdrAddr  = '0;
    sdrDqOe  = 1'b0;
    sdrDqm   = 2'b00;
    sdrDqOut = dataQ;
    case (strobe.cmd)
      CMD_PRE_ALL: sdrAddr = ALL_BANKS;
      CMD_ACT:     sdrAddr = SA_W'(curRow);
      CMD_READ:    sdrAddr = SA_W'(curCol);
      CMD_WRITE: begin
        sdrAddr = SA_W'(curCol);
        sdrDqOe = 1'b1;
        sdrDqm  = maskQ;
      end
      CMD_MRS:     sdrAddr = MODE_WORD;
      default:     sdrAddr = '0;
    endcase
  end

  // R8: read data is sampled exactly CAS latency after the read command
  a_r8_latch_at_cas: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchRd |-> ($past(strobe.cmd, CAS_LAT) == CMD_READ));

  // R7: the data bus is driven toward the SDRAM only with a write command
  a_r7_dq_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    sdrDqOe |-> (!sdrCasN && !sdrWeN && sdrRasN));

endmodule

// File: rtl/sram_sdram_bridge.sv
module sram_sdram_bridge
  import sdram_bridge_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DEC_W        = 1,
  parameter int DEC_BASE     = 0,
  parameter int COL_W        = 9,
  parameter int BANK_W       = 2,
  parameter int SA_W         = 13,
  parameter int T_PWRUP      = 2000,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int CAS_LAT      = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              hostRstN,
  input  logic [ADDR_W-1:0] hostAddr,
  inout  wire  [15:0]       hostData,
  input  logic              hostUbN,
  input  logic              hostLbN,
  input  logic              hostWeN,
  input  logic              hostOeN,
  input  logic              hostCsN,
  output wire               hostReady,
  output logic              sdrCke,
  output logic              sdrCsN,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic [BANK_W-1:0] sdrBa,
  output logic [SA_W-1:0]   sdrAddr,
  output logic [1:0]        sdrDqm,
  output logic [15:0]       sdrDqOut,
  input  logic [15:0]       sdrDqIn,
  output logic              sdrDqOe
);

  localparam int LOC_W = ADDR_W - DEC_W;
  localparam int ROW_W = LOC_W - COL_W - BANK_W;

  logic              decHit, selNow, readyPull, driveRd;
  logic [1:0]        selSync;
  logic              initDone, accessDone, curWrite;
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [15:0]       rdData;
  ctrlStrobe_t       strobe;

  generate
    if (DEC_W == 0) begin : g_noDecode
      assign decHit = 1'b1;
    end else begin : g_decode
      assign decHit = (hostAddr[ADDR_W-1 -: DEC_W] == DEC_W'(DEC_BASE));
    end
  endgenerate

  assign selNow = !hostCsN && decHit;

  always_ff @(posedge clk or negedge hostRstN) begin
    if (!hostRstN) begin
      selSync <= 2'b00;
      sdrCke  <= 1'b0;
    end else begin
      selSync <= {selSync[0], selNow};
      sdrCke  <= 1'b1;
    end
  end

  assign sdrCsN    = !sdrCke;
  assign readyPull = !initDone || (selNow && !accessDone);
  assign hostReady = readyPull ? 1'b0 : 1'bz;
  assign driveRd   = selNow && !hostOeN && hostWeN;
  assign hostData  = driveRd ? rdData : 16'bz;

  sdram_bridge_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .T_PWRUP(T_PWRUP), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR),
    .CAS_LAT(CAS_LAT), .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(hostRstN), .selReq(selSync[1]),
    .curBank(curBank), .curRow(curRow), .curWrite(curWrite),
    .strobe(strobe), .initDone(initDone), .accessDone(accessDone)
  );

  sdram_bridge_dp #(
    .LOC_W(LOC_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .SA_W(SA_W), .CAS_LAT(CAS_LAT)
  ) u_dp (
    .clk(clk), .rstN(hostRstN), .strobe(strobe),
    .hostAddr(hostAddr[LOC_W-1:0]), .hostDataIn(hostData),
    .hostUbN(hostUbN), .hostLbN(hostLbN), .hostWeN(hostWeN),
    .curBank(curBank), .curRow(curRow), .curWrite(curWrite),
    .sdrRasN(sdrRasN), .sdrCasN(sdrCasN), .sdrWeN(sdrWeN),
    .sdrBa(sdrBa), .sdrAddr(sdrAddr), .sdrDqm(sdrDqm),
    .sdrDqOut(sdrDqOut), .sdrDqOe(sdrDqOe), .sdrDqIn(sdrDqIn),
    .rdData(rdData)
  );

  // R3: ready is released while the block is idle and deselected
  a_r3_release_when_idle: assert property (@(posedge clk) disable iff (!hostRstN)
    (initDone && !selNow && !selSync[1]) |-> (hostReady !== 1'b0));

endmodule

// File: tb/sram_sdram_bridge_bench.sv
module sram_sdram_bridge_bench;

  localparam int T_PWRUP = 2000;
  localparam int T_RP = 2, T_RCD = 2, REF_INTERVAL = 780;

  logic        clk = 1'b0;
  logic        hostRstN;
  logic [23:0] hostAddr;
  logic        hostUbN, hostLbN, hostWeN, hostOeN, hostCsN;
  logic [15:0] tbData;
  logic        tbDrive;
  wire  [15:0] hostData;
  wire         hostReady;
  logic        sdrCke, sdrCsN, sdrRasN, sdrCasN, sdrWeN, sdrDqOe;
  logic [1:0]  sdrBa, sdrDqm;
  logic [12:0] sdrAddr;
  logic [15:0] sdrDqOut;
  logic [15:0] sdrDqIn;

  pullup (hostReady);
  assign hostData = tbDrive ? tbData : 16'bz;

  always #5 clk = ~clk;

  sram_sdram_bridge u_sram_sdram_bridge (
    .clk(clk), .hostRstN(hostRstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostUbN(hostUbN), .hostLbN(hostLbN), .hostWeN(hostWeN), .hostOeN(hostOeN),
    .hostCsN(hostCsN), .hostReady(hostReady), .sdrCke(sdrCke), .sdrCsN(sdrCsN),
    .sdrRasN(sdrRasN), .sdrCasN(sdrCasN), .sdrWeN(sdrWeN), .sdrBa(sdrBa),
    .sdrAddr(sdrAddr), .sdrDqm(sdrDqm), .sdrDqOut(sdrDqOut), .sdrDqIn(sdrDqIn),
    .sdrDqOe(sdrDqOe)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] defWord(input int key);
    return key[15:0] ^ 16'h5A3C;
  endfunction

  // ---------------- SDRAM model ----------------
  logic [15:0] mem [int];
  logic [11:0] mRow [4];
  logic [3:0]  mOpen;
  int lastPre [4];
  int lastAct [4];
  int cyc, initStep, refAfterInit, mrsCyc;
  logic [15:0] rdPipe;

  always @(posedge clk) begin
    if (!hostRstN) begin
      cyc = 0; initStep = 0; refAfterInit = 0; mrsCyc = 0; mOpen = 0;
      for (int b = 0; b < 4; b++) begin lastPre[b] = -100; lastAct[b] = -100; end
    end else begin
      cyc++;
      sdrDqIn <= rdPipe;
      if (!sdrCsN && {sdrRasN, sdrCasN, sdrWeN} != 3'b111) begin
        automatic logic [2:0] c = {sdrRasN, sdrCasN, sdrWeN};
        automatic int b = sdrBa;
        automatic int key = {mRow[b], sdrBa, sdrAddr[8:0]};
        if (initStep < 4) begin
          case (initStep)
            0: begin
              chk(c == 3'b010 && sdrAddr[10], "R1 first command precharge-all", c, 3'b010);
              chk(cyc >= T_PWRUP, "R1 power-up delay", cyc, T_PWRUP);
            end
            1, 2: chk(c == 3'b001, "R1 init refresh", c, 3'b001);
            3: begin
              chk(c == 3'b000, "R1 mode load", c, 3'b000);
              chk(sdrAddr == 13'h020, "R1 mode word", sdrAddr, 13'h020);
              mrsCyc = cyc;
            end
            default: ;
          endcase
          chk(c != 3'b011 && c != 3'b101 && c != 3'b100, "R2 access during init", c, 0);
          initStep++;
        end else begin
          case (c)
            3'b010: begin
              if (sdrAddr[10]) begin
                mOpen = 0;
                for (int k = 0; k < 4; k++) lastPre[k] = cyc;
              end else begin
                mOpen[b] = 1'b0; lastPre[b] = cyc;
              end
            end
            3'b011: begin
              chk(!mOpen[b], "R6 activate on open bank", mOpen[b], 0);
              chk(cyc - lastPre[b] >= T_RP, "R5 precharge to activate", cyc - lastPre[b], T_RP);
              mOpen[b] = 1'b1; mRow[b] = sdrAddr[11:0]; lastAct[b] = cyc;
            end
            3'b101, 3'b100: begin
              chk(mOpen[b], "R6 column command on closed bank", mOpen[b], 1);
              chk(cyc - lastAct[b] >= T_RCD, "R5 activate to column", cyc - lastAct[b], T_RCD);
              if (c == 3'b101) begin
                rdPipe <= mem.exists(key) ? mem[key] : defWord(key);
              end else begin
                automatic logic [15:0] w = mem.exists(key) ? mem[key] : defWord(key);
                if (!sdrDqm[1]) w[15:8] = sdrDqOut[15:8];
                if (!sdrDqm[0]) w[7:0] = sdrDqOut[7:0];
                mem[key] = w;
              end
            end
            3'b001: begin
              chk(mOpen == 0, "R4 refresh with open row", mOpen, 0);
              refAfterInit++;
            end
            default: chk(0, "R1 unexpected command", c, 0);
          endcase
        end
      end
    end
  end

  // ---------------- host side ----------------
  logic [15:0] refMem [int];

  function automatic logic [15:0] expWord(input logic [23:0] a);
    automatic int k = a[22:0];
    return refMem.exists(k) ? refMem[k] : defWord(k);
  endfunction

  function automatic logic [23:0] mkAddr(input int row, input int bank, input int col);
    return {1'b0, row[11:0], bank[1:0], col[8:0]};
  endfunction

  task automatic hostWrite(input logic [23:0] a, input logic [15:0] d,
                           input bit ub, input bit lb, output int lat, output bit sawLow);
    @(negedge clk);
    hostAddr = a; tbData = d; tbDrive = 1; hostWeN = 0; hostOeN = 1;
    hostUbN = !ub; hostLbN = !lb; hostCsN = 0;
    lat = 0;
    @(negedge clk); lat++;
    sawLow = (hostReady === 1'b0);
    while (hostReady === 1'b0 && lat < 1000) begin @(negedge clk); lat++; end
    hostCsN = 1; hostWeN = 1; tbDrive = 0; hostUbN = 1; hostLbN = 1;
    if (!a[23]) begin
      automatic int k = a[22:0];
      automatic logic [15:0] w = expWord(a);
      if (ub) w[15:8] = d[15:8];
      if (lb) w[7:0] = d[7:0];
      refMem[k] = w;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic hostRead(input logic [23:0] a, output logic [15:0] d, output int lat);
    @(negedge clk);
    hostAddr = a; tbDrive = 0; hostWeN = 1; hostOeN = 0;
    hostUbN = 0; hostLbN = 0; hostCsN = 0;
    lat = 0;
    @(negedge clk); lat++;
    chk(hostReady === 1'b0, "R3 ready pulled low on select", hostReady, 0);
    while (hostReady === 1'b0 && lat < 1000) begin @(negedge clk); lat++; end
    chk(lat < 1000, "R3 access completes", lat, 0);
    d = hostData;
    hostCsN = 1; hostOeN = 1; hostUbN = 1; hostLbN = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readCheck(input logic [23:0] a, input string tag, output int lat);
    logic [15:0] got;
    hostRead(a, got, lat);
    chk(got === expWord(a), tag, got, expWord(a));
  endtask

  initial begin
    int lc, lh, lm, lat, waitCyc;
    bit low;
    hostRstN = 0; hostAddr = 0; tbData = 0; tbDrive = 0;
    hostUbN = 1; hostLbN = 1; hostWeN = 1; hostOeN = 1; hostCsN = 1; rdPipe = 0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(hostReady === 1'b0, "R2 ready low in reset", hostReady, 0);
    hostRstN = 1;
    repeat (100) @(negedge clk);
    chk(hostReady === 1'b0, "R2 ready low during power-up", hostReady, 0);
    waitCyc = 0;
    while (hostReady === 1'b0 && waitCyc < 5000) begin @(negedge clk); waitCyc++; end
    chk(initStep == 4, "R1 init sequence complete", initStep, 4);
    chk(hostReady !== 1'b0, "R3 ready released when idle", hostReady, 1);

    // R6 / R10: closed bank, open-row hit, row miss
    readCheck(mkAddr(7, 2, 5), "R8 read closed bank", lc);
    readCheck(mkAddr(7, 2, 9), "R8 read open-row hit", lh);
    readCheck(mkAddr(8, 2, 9), "R10 read row miss", lm);
    chk(lh < lc, "R6 hit faster than closed", lh, lc);
    chk(lc < lm, "R6 closed faster than miss", lc, lm);

    // R7 byte lanes
    hostWrite(mkAddr(3, 1, 40), 16'h1234, 1, 1, lat, low);
    chk(low, "R3 ready low during write", low, 1);
    readCheck(mkAddr(3, 1, 40), "R7 full word write", lat);
    hostWrite(mkAddr(3, 1, 40), 16'hABCD, 1, 0, lat, low);
    readCheck(mkAddr(3, 1, 40), "R7 upper byte only", lat);
    hostWrite(mkAddr(3, 1, 40), 16'h99EE, 0, 1, lat, low);
    readCheck(mkAddr(3, 1, 40), "R7 lower byte only", lat);
    hostWrite(mkAddr(3, 1, 40), 16'h0000, 0, 0, lat, low);
    readCheck(mkAddr(3, 1, 40), "R7 no byte enabled", lat);

    // R9 decode window
    hostWrite(mkAddr(3, 1, 40) | 24'h800000, 16'hDEAD, 1, 1, lat, low);
    chk(!low, "R9 ready released outside window", low, 0);
    readCheck(mkAddr(3, 1, 40), "R9 alias unchanged", lat);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      automatic logic [23:0] a = mkAddr($urandom % 4, $urandom % 4, $urandom % 16);
      if (($urandom % 10) < 6)
        hostWrite(a, 16'($urandom), 1'($urandom), 1'($urandom), lat, low);
      else
        readCheck(a, "R8 random read", lat);
    end

    repeat (3000) @(negedge clk);
    chk(hostReady !== 1'b0, "R3 ready released after idle", hostReady, 1);
    begin
      automatic int expRef = (cyc - mrsCyc) / REF_INTERVAL;
      chk(refAfterInit >= expRef - 1 && refAfterInit <= expRef + 1,
          "R4 refresh rate", refAfterInit, expRef);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule